// File: doc/BRIEF.md
# Page-Mode Word Memory Front End

This block is a clocked model of a word-wide memory that behaves like an asynchronous static RAM from the host side. Its storage array sits inside the block. Every control pin is sampled on each rising clock edge. These are the chip select, the write strobe, the output enable, one select per byte lane and a sleep request. From those samples the block finds edges and runs a small access sequencer. A falling chip select opens a row. Once the initial access time has passed, the row's word is ready. After that, the lowest address bits pick a column inside the open row, and each column is reached in the shorter page time. Chip select does not have to toggle between columns.

The row is closed and the array precharges in two cases: chip select goes high, or the upper address bits change while chip select stays low. In the second case the new row is then opened without any action from the host. Writes commit on the first rising edge of either the write strobe or the chip select, and only the enabled lanes change. A write costs no extra cycles. The block computes a drive enable for each byte lane of the data bus and a `data_valid` flag that marks the cycles in which the read data is good. A sleep request freezes every other input. After sleep ends, new accesses wait out a fixed exit delay.

Storage is 2^ADDR_W words. ADDR_W = 17 gives the full 131072-word size, which is 8 blocks of 4096 rows with 4 columns each. The default is kept small so that elaboration stays light. The timing parameters must satisfy 2*T_PAGE < T_ACC.

Top module: `pgmem_ctrl`

## Requirements
- R1: Word address `addr` splits into row = `addr[ADDR_W-1:COL_W]` and column = `addr[COL_W-1:0]` (COL_W = 2). Every word written reads back with the written lanes replaced and the other lanes kept.
- R2: If the sequencer is idle and `mem_sel_n` is sampled low after being high, the row is latched from `addr`. `data_valid` goes high exactly T_ACC clock edges after that sampling edge, and `dq_out` then holds the addressed word.
- R3: In an open row with `mem_sel_n` held low, a change of the column bits drops `data_valid` after the edge that samples it. `data_valid` rises again T_PAGE edges after that edge, and `dq_out` then holds the word at the new column.
- R4: Sampling `mem_sel_n` high closes the row, and `data_valid` is low after that edge. A chip-select fall sampled during the T_PRE-cycle precharge is held back: `data_valid` rises T_PRE+T_ACC edges after the edge that sampled the rise.
- R5: `dq_drive[i]` is high only when `data_valid` is high, `rd_en_n` is low and `byte_n[i]` is low. Lane 1 is `dq_out[15:8]` and lane 0 is `dq_out[7:0]`. With `rd_en_n` high the bus is not driven, but `data_valid` still shows readiness.
- R6: While `wr_n` is low, `dq_drive` is all zero and `data_valid` is low, whatever `rd_en_n` is.
- R7: A write commits at the first edge that samples `wr_n` high or `mem_sel_n` high after a cycle with both low. It uses the column, `dq_in` and `byte_n` sampled in that previous cycle. This works for a write strobe that is low when chip select falls and for one that falls later in an open row. A read of the written word is valid T_PAGE edges after the commit, with no added busy time.
- R8: While `sleep_n` is sampled low, `data_valid` and `dq_drive` are low and all other inputs are ignored, so no write reaches the array. A chip-select fall sampled within T_ZZX edges after `sleep_n` is sampled high again does not start an access.
- R9: A change of the row bits while `mem_sel_n` stays low drops `data_valid`. The new row's word is then valid T_PRE+T_ACC edges after the edge that sampled the change.
- R10: After reset, `data_valid` is low and `dq_drive` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_sel_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_en_n | input | 1 | Output enable, active low |
| byte_n | input | DATA_W/8 | Per-lane byte select, active low (bit 1 = upper byte) |
| sleep_n | input | 1 | Sleep request, active low |
| addr | input | ADDR_W | Word address; low COL_W bits are the column |
| dq_in | input | DATA_W | Write data from the bus |
| dq_out | output | DATA_W | Read data toward the bus |
| dq_drive | output | DATA_W/8 | Per-lane bus drive enable |
| data_valid | output | 1 | Read data on `dq_out` is valid |

## Verification
The bench builds the block with ADDR_W = 8, T_ACC = 5, T_PAGE = 2, T_PRE = 3 and T_ZZX = 4. With only 256 words, the bench can preload every word with chip-select-controlled writes and keep a full reference image, so random reads anywhere in the array are checked. The short counts make the corner cases cheap to hit with exact cycle counts: a chip-select fall inside the precharge window, a row change while selected, and a chip-select fall inside the sleep-exit window.

// File: rtl/pm_pkg.sv
package pm_pkg;

    localparam int LANE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_ACC,
        ST_OPEN,
        ST_SLEEP,
        ST_WAKE
    } pm_state_e;

    typedef struct packed {
        logic sel_n;
        logic wr_n;
        logic rd_n;
        logic sleep_n;
    } pm_ctl_t;

    function automatic int max4(int a, int b, int c, int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/pm_seq.sv
module pm_seq
    import pm_pkg::*;
#(
    parameter int ROW_W  = 6,
    parameter int COL_W  = 2,
    parameter int T_ACC  = 6,
    parameter int T_PAGE = 2,
    parameter int T_PRE  = 3,
    parameter int T_ZZX  = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  pm_ctl_t          ctl,
    input  logic [ROW_W-1:0] row_in,
    input  logic [COL_W-1:0] col_in,
    output pm_state_e        state,
    output logic [ROW_W-1:0] row_q,
    output logic             page_ok,
    output logic             wr_fire
);
    localparam int TMAX = max4(T_ACC, T_PAGE, T_PRE, T_ZZX);
    localparam int CW   = $clog2(TMAX + 1);

    logic [CW-1:0]    cnt;
    logic [CW-1:0]    page_cnt;
    logic [COL_W-1:0] col_q;
    logic             prev_sel_n;
    logic             prev_wr_n;
    logic             sel_fall;
    logic             row_chg;
    logic             row_busy;

    assign sel_fall = prev_sel_n & ~ctl.sel_n;
    assign row_chg  = (row_in != row_q);
    assign row_busy = (state == ST_ACC) || (state == ST_OPEN);
    assign wr_fire  = row_busy && ctl.sleep_n && !prev_wr_n && !prev_sel_n
                      && (ctl.wr_n || ctl.sel_n);
    assign page_ok  = (page_cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            cnt        <= '0;
            page_cnt   <= '0;
            row_q      <= '0;
            col_q      <= '0;
            prev_sel_n <= 1'b1;
            prev_wr_n  <= 1'b1;
        end else begin
            prev_sel_n <= ctl.sel_n;
            prev_wr_n  <= ctl.wr_n;
            col_q      <= col_in;
            if (page_cnt != '0) page_cnt <= page_cnt - 1'b1;

            if (!ctl.sleep_n) begin
                state <= ST_SLEEP;
            end else begin
                case (state)
                    ST_IDLE: begin
                        if (sel_fall) begin
                            row_q <= row_in;
                            state <= ST_ACC;
                            cnt   <= CW'(T_ACC - 1);
                        end
                    end
                    ST_PRE: begin
                        if (sel_fall) row_q <= row_in;
                        if (cnt == '0) begin
                            if (!ctl.sel_n) begin
                                state <= ST_ACC;
                                cnt   <= CW'(T_ACC - 1);
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                    end
                    ST_ACC, ST_OPEN: begin
                        if (ctl.sel_n) begin
                            state <= ST_PRE;
                            cnt   <= CW'(T_PRE - 1);
                        end else if (row_chg) begin
                            row_q <= row_in;
                            state <= ST_PRE;
                            cnt   <= CW'(T_PRE - 1);
                        end else if (state == ST_ACC) begin
                            if (cnt == '0) begin
                                state    <= ST_OPEN;
                                page_cnt <= wr_fire ? CW'(T_PAGE) : '0;
                            end else begin
                                cnt <= cnt - 1'b1;
                            end
                        end else if ((col_in != col_q) || wr_fire) begin
                            page_cnt <= CW'(T_PAGE);
                        end
                    end
                    ST_SLEEP: begin
                        state <= ST_WAKE;
                        cnt   <= CW'(T_ZZX - 1);
                    end
                    ST_WAKE: begin
                        if (cnt == '0) state <= ST_IDLE;
                        else           cnt   <= cnt - 1'b1;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/pm_array.sv
module pm_array
    import pm_pkg::*;
#(
    parameter int ROW_W  = 6,
    parameter int COL_W  = 2,
    parameter int DATA_W = 16,
    parameter int LANES  = DATA_W / LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_fire,
    input  logic [ROW_W-1:0]  row_q,
    input  logic [COL_W-1:0]  col_in,
    input  logic [DATA_W-1:0] din,
    input  logic [LANES-1:0]  byte_n,
    output logic [DATA_W-1:0] rd_q
);
    localparam int DEPTH = 1 << (ROW_W + COL_W);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [COL_W-1:0]  prev_col;
    logic [DATA_W-1:0] prev_din;
    logic [LANES-1:0]  prev_byte_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_col    <= '0;
            prev_din    <= '0;
            prev_byte_n <= '1;
            rd_q        <= '0;
        end else begin
            prev_col    <= col_in;
            prev_din    <= din;
            prev_byte_n <= byte_n;
            rd_q        <= mem[{row_q, col_in}];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && wr_fire) begin
            for (int i = 0; i < LANES; i++) begin
                if (!prev_byte_n[i])
                    mem[{row_q, prev_col}][i*LANE_W +: LANE_W] <= prev_din[i*LANE_W +: LANE_W];
            end
        end
    end

endmodule

// File: rtl/pm_bus.sv
module pm_bus
    import pm_pkg::*;
#(
    parameter int LANES = 2
) (
    input  pm_state_e        state,
    input  logic             page_ok,
    input  pm_ctl_t          ctl,
    input  logic [LANES-1:0] byte_n,
    output logic [LANES-1:0] dq_drive,
    output logic             data_valid
);
    assign data_valid = (state == ST_OPEN) && page_ok && ctl.wr_n && ctl.sleep_n;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign dq_drive[g] = data_valid && !ctl.rd_n && !byte_n[g];
    end

endmodule

// File: rtl/pgmem_ctrl.sv
module pgmem_ctrl
    import pm_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16,
    parameter int COL_W  = 2,
    parameter int T_ACC  = 6,
    parameter int T_PAGE = 2,
    parameter int T_PRE  = 3,
    parameter int T_ZZX  = 5
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       mem_sel_n,
    input  logic                       wr_n,
    input  logic                       rd_en_n,
    input  logic [DATA_W/LANE_W-1:0]   byte_n,
    input  logic                       sleep_n,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          dq_in,
    output logic [DATA_W-1:0]          dq_out,
    output logic [DATA_W/LANE_W-1:0]   dq_drive,
    output logic                       data_valid
);
    localparam int ROW_W = ADDR_W - COL_W;
    localparam int LANES = DATA_W / LANE_W;

    pm_ctl_t          ctl;
    pm_state_e        state;
    logic [ROW_W-1:0] row_q;
    logic             page_ok;
    logic             wr_fire;

    assign ctl = '{sel_n: mem_sel_n, wr_n: wr_n, rd_n: rd_en_n, sleep_n: sleep_n};

    pm_seq #(
        .ROW_W(ROW_W), .COL_W(COL_W), .T_ACC(T_ACC),
        .T_PAGE(T_PAGE), .T_PRE(T_PRE), .T_ZZX(T_ZZX)
    ) u_seq (
        .clk(clk), .rst(rst), .ctl(ctl),
        .row_in(addr[ADDR_W-1:COL_W]), .col_in(addr[COL_W-1:0]),
        .state(state), .row_q(row_q), .page_ok(page_ok), .wr_fire(wr_fire)
    );

    pm_array #(
        .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .LANES(LANES)
    ) u_array (
        .clk(clk), .rst(rst), .wr_fire(wr_fire), .row_q(row_q),
        .col_in(addr[COL_W-1:0]), .din(dq_in), .byte_n(byte_n), .rd_q(dq_out)
    );

    pm_bus #(.LANES(LANES)) u_bus (
        .state(state), .page_ok(page_ok), .ctl(ctl), .byte_n(byte_n),
        .dq_drive(dq_drive), .data_valid(data_valid)
    );

endmodule

// File: rtl/pm_check.sv
module pm_check #(
    parameter int LANES = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             mem_sel_n,
    input logic             wr_n,
    input logic             rd_en_n,
    input logic [LANES-1:0] byte_n,
    input logic             sleep_n,
    input logic [LANES-1:0] dq_drive,
    input logic             data_valid
);
    a_r6_quiet_while_writing: assert property (@(posedge clk) disable iff (rst)
        !wr_n |-> (dq_drive == '0 && !data_valid));

    a_r5_lane_gate: assert property (@(posedge clk) disable iff (rst)
        (dq_drive & byte_n) == '0);

    a_r5_oe_gate: assert property (@(posedge clk) disable iff (rst)
        rd_en_n |-> dq_drive == '0);

    a_r8_sleep_blocks: assert property (@(posedge clk) disable iff (rst)
        !sleep_n |=> (!data_valid && dq_drive == '0));

    a_r4_sel_high_closes: assert property (@(posedge clk) disable iff (rst)
        mem_sel_n |=> !data_valid);

    a_r2_valid_needs_sel: assert property (@(posedge clk) disable iff (rst)
        data_valid |-> $past(!mem_sel_n));

endmodule

bind pgmem_ctrl pm_check #(.LANES(LANES)) u_chk (
    .clk(clk), .rst(rst), .mem_sel_n(mem_sel_n), .wr_n(wr_n),
    .rd_en_n(rd_en_n), .byte_n(byte_n), .sleep_n(sleep_n),
    .dq_drive(dq_drive), .data_valid(data_valid)
);

// File: tb/pgmem_ctrl_test.sv
module pgmem_ctrl_test;
    localparam int AW = 8, DW = 16, LN = 2;
    localparam int TA = 5, TP = 2, TR = 3, TZ = 4;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0, rst = 1'b1;
    logic mem_sel_n = 1'b1, wr_n = 1'b1, rd_en_n = 1'b0, sleep_n = 1'b1;
    logic [LN-1:0] byte_n = '0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] dq_in = '0;
    logic [DW-1:0] dq_out;
    logic [LN-1:0] dq_drive;
    logic data_valid;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [DW-1:0] model [DEPTH];

    always #2 clk = ~clk;

    pgmem_ctrl #(.ADDR_W(AW), .DATA_W(DW), .COL_W(2), .T_ACC(TA),
                 .T_PAGE(TP), .T_PRE(TR), .T_ZZX(TZ)) uut (
        .clk(clk), .rst(rst), .mem_sel_n(mem_sel_n), .wr_n(wr_n),
        .rd_en_n(rd_en_n), .byte_n(byte_n), .sleep_n(sleep_n), .addr(addr),
        .dq_in(dq_in), .dq_out(dq_out), .dq_drive(dq_drive), .data_valid(data_valid)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_w,
                                            input logic [DW-1:0] new_w,
                                            input logic [LN-1:0] bn);
        logic [DW-1:0] r;
        r = old_w;
        for (int i = 0; i < LN; i++)
            if (!bn[i]) r[i*8 +: 8] = new_w[i*8 +: 8];
        return r;
    endfunction

    task automatic nx();
        @(negedge clk);
    endtask

    task automatic wait_n(input int n);
        repeat (n) nx();
    endtask

    // R2: open a row from idle and check exact access latency
    task automatic open_read(input logic [AW-1:0] a, input logic [LN-1:0] bn);
        addr = a; mem_sel_n = 1'b0; wr_n = 1'b1; rd_en_n = 1'b0; byte_n = bn;
        wait_n(TA);
        chk(data_valid == 1'b0, "R2", "valid before access time", 32'(data_valid), 0);
        nx();
        chk(data_valid == 1'b1, "R2", "valid at access time", 32'(data_valid), 1);
        chk(dq_out == model[a], "R1", "read word", 32'(dq_out), 32'(model[a]));
        chk(dq_drive == ~bn, "R5", "lane drive", 32'(dq_drive), 32'(~bn));
    endtask

    task automatic close_row();
        mem_sel_n = 1'b1; wr_n = 1'b1;
        nx();
        chk(data_valid == 1'b0, "R4", "valid after deselect", 32'(data_valid), 0);
        wait_n(TR);
    endtask

    // R3: page access in the open row
    task automatic page_read(input logic [1:0] col);
        logic [1:0] c;
        c = col;
        if (c == addr[1:0]) c = c ^ 2'b01;
        addr[1:0] = c; byte_n = '0;
        wait_n(TP);
        chk(data_valid == 1'b0, "R3", "valid before page time", 32'(data_valid), 0);
        nx();
        chk(data_valid == 1'b1, "R3", "valid at page time", 32'(data_valid), 1);
        chk(dq_out == model[addr], "R3", "page word", 32'(dq_out), 32'(model[addr]));
    endtask

    // R7: write-strobe-controlled write inside an open row, then read back
    task automatic we_write(input logic [1:0] col, input logic [DW-1:0] d,
                            input logic [LN-1:0] bn);
        addr[1:0] = col; dq_in = d; byte_n = bn; wr_n = 1'b0; rd_en_n = 1'b0;
        #1;
        chk(dq_drive == '0, "R6", "drive while write strobe low", 32'(dq_drive), 0);
        chk(data_valid == 1'b0, "R6", "valid while write strobe low", 32'(data_valid), 0);
        nx();
        wr_n = 1'b1; byte_n = '0;
        model[addr] = merge(model[addr], d, bn);
        wait_n(TP);
        chk(data_valid == 1'b0, "R7", "valid before write settle", 32'(data_valid), 0);
        nx();
        chk(data_valid == 1'b1, "R7", "valid after write", 32'(data_valid), 1);
        chk(dq_out == model[addr], "R7", "lane-merged write", 32'(dq_out), 32'(model[addr]));
    endtask

    // R7: chip-select-controlled write (strobe low when select falls)
    task automatic ce_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        addr = a; dq_in = d; byte_n = '0; mem_sel_n = 1'b0; wr_n = 1'b0;
        wait_n(2);
        mem_sel_n = 1'b1; wr_n = 1'b1;
        model[a] = d;
        wait_n(TR + 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] a, b, c, x;
        logic [LN-1:0] bsel [3];
        void'($urandom(32'd2024));
        bsel[0] = 2'b00; bsel[1] = 2'b01; bsel[2] = 2'b10;
        wait_n(3);
        rst = 1'b0;
        nx();
        // R10: reset state
        chk(data_valid == 1'b0, "R10", "valid after reset", 32'(data_valid), 0);
        chk(dq_drive == '0, "R10", "drive after reset", 32'(dq_drive), 0);

        for (int i = 0; i < DEPTH; i++) ce_write(AW'(i), DW'($urandom));

        // R1/R2: directed read
        open_read(8'h27, 2'b00);
        page_read(2'b00);
        // R5: output enable high leaves bus undriven but data ready
        rd_en_n = 1'b1; #1;
        chk(dq_drive == '0, "R5", "drive with OE high", 32'(dq_drive), 0);
        chk(data_valid == 1'b1, "R5", "valid with OE high", 32'(data_valid), 1);
        rd_en_n = 1'b0;
        // R5: upper lane only
        byte_n = 2'b01; #1;
        chk(dq_drive == 2'b10, "R5", "upper lane only", 32'(dq_drive), 2);
        byte_n = 2'b00;
        close_row();

        // R9: row change while selected
        a = 8'h40; b = 8'h93;
        open_read(a, 2'b00);
        addr = b;
        nx();
        chk(data_valid == 1'b0, "R9", "valid right after row change", 32'(data_valid), 0);
        wait_n(TR + TA - 1);
        chk(data_valid == 1'b0, "R9", "valid before reopen", 32'(data_valid), 0);
        nx();
        chk(data_valid == 1'b1, "R9", "valid after reopen", 32'(data_valid), 1);
        chk(dq_out == model[b], "R9", "new row word", 32'(dq_out), 32'(model[b]));

        // R4: select falls during precharge and is deferred
        c = 8'h5a;
        mem_sel_n = 1'b1;
        nx();
        mem_sel_n = 1'b0; addr = c;
        wait_n(TR + TA - 1);
        chk(data_valid == 1'b0, "R4", "valid before deferred access", 32'(data_valid), 0);
        nx();
        chk(data_valid == 1'b1, "R4", "deferred access valid", 32'(data_valid), 1);
        chk(dq_out == model[c], "R4", "deferred word", 32'(dq_out), 32'(model[c]));
        we_write(2'b11, 16'hbeef, 2'b10);
        close_row();

        // R8: sleep blocks everything, then exit delay
        x = 8'hc4;
        open_read(x, 2'b00);
        sleep_n = 1'b0;
        nx();
        chk(data_valid == 1'b0, "R8", "valid in sleep", 32'(data_valid), 0);
        chk(dq_drive == '0, "R8", "drive in sleep", 32'(dq_drive), 0);
        mem_sel_n = 1'b1; nx();
        mem_sel_n = 1'b0; wr_n = 1'b0; dq_in = ~model[x]; byte_n = '0; addr = x;
        wait_n(2);
        mem_sel_n = 1'b1; wr_n = 1'b1;
        nx();
        sleep_n = 1'b1;
        nx();
        mem_sel_n = 1'b0;
        wait_n(TZ + TA + 3);
        chk(data_valid == 1'b0, "R8", "select during wake ignored", 32'(data_valid), 0);
        mem_sel_n = 1'b1;
        wait_n(TR + 1);
        open_read(x, 2'b00);
        close_row();

        // random mix of reads, page reads and lane writes
        for (int it = 0; it < 60; it++) begin
            a = AW'($urandom);
            open_read(a, bsel[$urandom % 3]);
            page_read(2'($urandom));
            page_read(2'($urandom));
            if ($urandom % 2)
                we_write(2'($urandom), DW'($urandom), bsel[$urandom % 3]);
            close_row();
            if ($urandom % 4 == 0) ce_write(AW'($urandom), DW'($urandom));
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule